// File: doc/BRIEF.md
# Firmware Boot Load Sequencer

This block brings up an embedded processor whose program memory is filled through an indirect load port. On a start pulse it takes the image length and drives a fixed sequence on a simple register-bus master. It first reads the processor control register and writes it back so that the processor is held in load mode. It then programs the load base address, reads and writes back the indirect command register and reads the indirect status register as a sanity check. Each 16-bit word from the incoming byte stream goes to the load register. After the last word the block programs the run vector in two halves and writes the control register back once more so that the processor runs.

Bytes arrive on a valid/ready stream. Each register access is held on the bus until the responder returns a done pulse. While one load write waits for its done pulse, the next word is assembled from the stream. The block signals its state with `busy`, and `ok` or `err` remains set from the end of a run until the next accepted start.

Top module: `fw_boot_seq`

## Requirements
- R1: After reset, `busy`, `ok`, `err`, `bus_req` and `s_ready` are all low.
- R2: A start with an odd `img_len` (bit 0 set) sets `err` on the next cycle. `busy` stays low, no bus access is made and no byte is accepted.
- R3: The first accesses are a read of address 0x000E, then a write to 0x000E of the value read with bits 4:0 replaced by 5'b10111. Bits 15:5 keep their value.
- R4: The third access writes 0x1000 to address 0x0100.
- R5: Next comes a read of 0x0101, then a write to 0x0101 of the read value ANDed with ~0x3FFC and ORed with 0xC000.
- R6: Next comes a read of 0x0103. If the value read is greater than 1, the run ends with `err` high and no further access, and no stream byte is ever accepted.
- R7: Bytes are paired in arrival order, with the first byte of a pair as bits 7:0 and the second as bits 15:8. Exactly `img_len`/2 writes to 0x0102 follow, in stream order. A zero length gives no load writes.
- R8: After the last load write, 0x2000 is written to 0x0003 and then 0x0000 to 0x0004.
- R9: The run ends with a read of 0x000E and a write to 0x000E of the value read with bits 4:0 set to 5'b00001. After the done pulse of that write, `ok` is high and `busy` is low.
- R10: `bus_req` remains high with a stable address, direction and write data until a cycle with `bus_done`, drops on the next cycle, and at most one access is outstanding.
- R11: `busy` rises on the cycle after an accepted start and stays high until the run ends. A start while busy is ignored.
- R12: Stream bytes are accepted only in the streaming phase. At most one assembled word waits for its write, and a stalled or gappy stream only delays the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken when idle |
| img_len | input | LEN_W | Image length in bytes |
| s_data | input | 8 | Image byte |
| s_valid | input | 1 | Byte valid |
| s_ready | output | 1 | Byte accepted when high with s_valid |
| bus_req | output | 1 | Access request, held until done |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_done |
| bus_done | input | 1 | Access completion pulse |
| busy | output | 1 | Sequence in progress |
| ok | output | 1 | Last run completed |
| err | output | 1 | Last run rejected or aborted |

## Verification
Two pieces of work can land in the same cycle. One is the capture of the next stream byte into the word assembler. The other is a load write still waiting for its done pulse, or the consumption of that pulse. Some runs use a slow responder and a stream that is always valid, so the next word is complete long before the previous write finishes. Other runs use a gappy stream and a fast responder. A second start pulse in the middle of a run must leave the run untouched. The bench judges each access at the moment the responder completes it, comparing it against a queue built from the requirements.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CTL_RD, S_CTL_WR, S_BASE_WR, S_IND_RD, S_IND_WR, S_STS_RD,
    S_STREAM, S_VLO_WR, S_VHI_WR, S_RUN_RD, S_RUN_WR
  } seq_state_t;

  localparam logic [15:0] ADR_CTL  = 16'h000E;
  localparam logic [15:0] ADR_BASE = 16'h0100;
  localparam logic [15:0] ADR_IND  = 16'h0101;
  localparam logic [15:0] ADR_LOAD = 16'h0102;
  localparam logic [15:0] ADR_STS  = 16'h0103;
  localparam logic [15:0] ADR_VLO  = 16'h0003;
  localparam logic [15:0] ADR_VHI  = 16'h0004;

  localparam logic [15:0] CTL_MASK = 16'h001F;
  localparam logic [15:0] CTL_HOLD = 16'h0017;
  localparam logic [15:0] CTL_GO   = 16'h0001;
  localparam logic [15:0] IND_CLR  = 16'h3FFC;
  localparam logic [15:0] IND_SET  = 16'hC000;
endpackage

// File: rtl/fbs_bus_port.sv
module fbs_bus_port #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss,
  input  logic          iss_we,
  input  logic [AW-1:0] iss_addr,
  input  logic [DW-1:0] iss_wdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_done,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (bus_req && bus_done) begin
        bus_req   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= bus_rdata;
      end else if (iss && !bus_req) begin
        bus_req   <= 1'b1;
        bus_we    <= iss_we;
        bus_addr  <= iss_addr;
        bus_wdata <= iss_wdata;
      end
    end
  end
endmodule

// File: rtl/fbs_packer.sv
module fbs_packer #(
  parameter int LEN_W = 16,
  parameter int DW    = 16,
  localparam int BW   = DW / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             en,
  input  logic [BW-1:0]    s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             word_valid,
  output logic [DW-1:0]    word,
  input  logic             pop
);
  logic [LEN_W-1:0] remain;
  logic             have_lo;
  logic [BW-1:0]    lo_q;

  assign s_ready = en && (remain != '0) && !word_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain     <= '0;
      have_lo    <= 1'b0;
      lo_q       <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else if (load) begin
      remain     <= len;
      have_lo    <= 1'b0;
      word_valid <= 1'b0;
    end else begin
      if (pop) word_valid <= 1'b0;
      if (s_valid && s_ready) begin
        remain <= remain - 1'b1;
        if (!have_lo) begin
          lo_q    <= s_data;
          have_lo <= 1'b1;
        end else begin
          word       <= {s_data, lo_q};
          word_valid <= 1'b1;
          have_lo    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fw_boot_seq.sv
module fw_boot_seq #(
  parameter int          LEN_W     = 16,
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter logic [15:0] LOAD_BASE = 16'h1000,
  parameter logic [31:0] RUN_VEC   = 32'h0000_2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             bus_req,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_done,
  output logic             busy,
  output logic             ok,
  output logic             err
);
  import fbs_pkg::*;

  seq_state_t       state;
  logic             pend;
  logic [DW-1:0]    hold;
  logic [LEN_W-1:0] words_left;

  logic          need, acc_we, iss, pop, rsp_valid, word_valid, load;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata, rsp_data, word;

  assign load = start && (state == S_IDLE) && !busy && !img_len[0];

  always_comb begin
    need      = 1'b1;
    acc_we    = 1'b1;
    acc_addr  = '0;
    acc_wdata = '0;
    case (state)
      S_CTL_RD:  begin acc_we = 1'b0; acc_addr = AW'(ADR_CTL); end
      S_CTL_WR:  begin acc_addr = AW'(ADR_CTL);  acc_wdata = DW'((hold & ~CTL_MASK) | CTL_HOLD); end
      S_BASE_WR: begin acc_addr = AW'(ADR_BASE); acc_wdata = DW'(LOAD_BASE); end
      S_IND_RD:  begin acc_we = 1'b0; acc_addr = AW'(ADR_IND); end
      S_IND_WR:  begin acc_addr = AW'(ADR_IND);  acc_wdata = DW'((hold & ~IND_CLR) | IND_SET); end
      S_STS_RD:  begin acc_we = 1'b0; acc_addr = AW'(ADR_STS); end
      S_STREAM:  begin
        need      = (words_left != '0) && word_valid;
        acc_addr  = AW'(ADR_LOAD);
        acc_wdata = word;
      end
      S_VLO_WR:  begin acc_addr = AW'(ADR_VLO); acc_wdata = DW'(RUN_VEC[15:0]); end
      S_VHI_WR:  begin acc_addr = AW'(ADR_VHI); acc_wdata = DW'(RUN_VEC[31:16]); end
      S_RUN_RD:  begin acc_we = 1'b0; acc_addr = AW'(ADR_CTL); end
      S_RUN_WR:  begin acc_addr = AW'(ADR_CTL); acc_wdata = DW'((hold & ~CTL_MASK) | CTL_GO); end
      default:   need = 1'b0;
    endcase
  end

  assign iss = need && !pend;
  assign pop = iss && (state == S_STREAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      pend       <= 1'b0;
      hold       <= '0;
      words_left <= '0;
      busy       <= 1'b0;
      ok         <= 1'b0;
      err        <= 1'b0;
    end else begin
      if (state == S_IDLE) begin
        if (start && !busy) begin
          ok <= 1'b0;
          if (img_len[0]) begin
            err <= 1'b1;
          end else begin
            err        <= 1'b0;
            busy       <= 1'b1;
            words_left <= img_len >> 1;
            state      <= S_CTL_RD;
          end
        end
      end else if (state == S_STREAM && words_left == '0 && !pend) begin
        state <= S_VLO_WR;
      end
      if (iss) pend <= 1'b1;
      if (rsp_valid) begin
        pend <= 1'b0;
        hold <= rsp_data;
        case (state)
          S_CTL_RD:  state <= S_CTL_WR;
          S_CTL_WR:  state <= S_BASE_WR;
          S_BASE_WR: state <= S_IND_RD;
          S_IND_RD:  state <= S_IND_WR;
          S_IND_WR:  state <= S_STS_RD;
          S_STS_RD:  begin
            if (rsp_data > DW'(1)) begin
              state <= S_IDLE;
              busy  <= 1'b0;
              err   <= 1'b1;
            end else begin
              state <= S_STREAM;
            end
          end
          S_STREAM:  words_left <= words_left - 1'b1;
          S_VLO_WR:  state <= S_VHI_WR;
          S_VHI_WR:  state <= S_RUN_RD;
          S_RUN_RD:  state <= S_RUN_WR;
          S_RUN_WR:  begin
            state <= S_IDLE;
            busy  <= 1'b0;
            ok    <= 1'b1;
          end
          default:   state <= S_IDLE;
        endcase
      end
    end
  end

  fbs_bus_port #(.AW(AW), .DW(DW)) port_i (
    .clk(clk), .rst(rst), .iss(iss), .iss_we(acc_we), .iss_addr(acc_addr),
    .iss_wdata(acc_wdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_done(bus_done), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  fbs_packer #(.LEN_W(LEN_W), .DW(DW)) pack_i (
    .clk(clk), .rst(rst), .load(load), .len(img_len),
    .en(state == S_STREAM), .s_data(s_data), .s_valid(s_valid),
    .s_ready(s_ready), .word_valid(word_valid), .word(word), .pop(pop)
  );
endmodule

// File: rtl/fbs_seq_chk.sv
module fbs_seq_chk #(
  parameter int LEN_W = 16,
  parameter int AW    = 16,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [LEN_W-1:0] img_len,
  input logic [7:0]       s_data,
  input logic             s_valid,
  input logic             s_ready,
  input logic             bus_req,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             bus_done,
  input logic             busy,
  input logic             ok,
  input logic             err
);
  a_r10_hold_until_done: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_done |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  a_r10_release_after_done: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_done |=> !bus_req);

  a_r11_req_only_busy: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

  a_r12_ready_only_busy: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> busy);

  a_r2_odd_reject: assert property (@(posedge clk) disable iff (rst)
    start && !busy && img_len[0] |=> err && !busy && !bus_req);

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ok && err) && !(busy && (ok || err)));
endmodule

bind fw_boot_seq fbs_seq_chk #(.LEN_W(LEN_W), .AW(AW), .DW(DW)) chk_i (.*);

// File: tb/fw_boot_seq_tb_top.sv
module fw_boot_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] img_len = '0;
  logic [7:0]  s_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready, bus_req, bus_we, busy, ok, err;
  logic [15:0] bus_addr, bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_done = 1'b0;

  int tests = 0;
  int fails = 0;
  int lat = 0;
  int wcnt = 0;
  int acc_cnt = 0;
  logic [15:0] rf [int];
  bit          exp_we [$];
  logic [15:0] exp_addr [$];
  logic [15:0] exp_data [$];

  always #2 clk = ~clk;

  fw_boot_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .img_len(img_len), .s_data(s_data),
    .s_valid(s_valid), .s_ready(s_ready), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_done(bus_done), .busy(busy), .ok(ok), .err(err)
  );

  task automatic chk(input bit c, input string req, input string what,
                     input int act, input int expv);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  function automatic string req_of(input logic [15:0] a);
    case (a)
      16'h000E: return "R3/R9";
      16'h0100: return "R4";
      16'h0101: return "R5";
      16'h0103: return "R6";
      16'h0102: return "R7";
      16'h0003, 16'h0004: return "R8";
      default:  return "R10";
    endcase
  endfunction

  // register-file responder, acts on falling edges
  always @(negedge clk) begin
    if (bus_done) begin
      bus_done = 1'b0;
    end else if (bus_req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        bus_done = 1'b1;
        if (exp_addr.size() == 0) begin
          chk(1'b0, req_of(bus_addr), "unexpected access addr", int'(bus_addr), 0);
        end else begin
          chk(bus_we == exp_we[0] && bus_addr == exp_addr[0], req_of(exp_addr[0]),
              "access dir/addr", int'({bus_we, bus_addr}), int'({exp_we[0], exp_addr[0]}));
          if (exp_we[0])
            chk(bus_wdata == exp_data[0], req_of(exp_addr[0]), "write data",
                int'(bus_wdata), int'(exp_data[0]));
          void'(exp_we.pop_front());
          void'(exp_addr.pop_front());
          void'(exp_data.pop_front());
        end
        if (bus_we) rf[int'(bus_addr)] = bus_wdata;
        else bus_rdata = rf.exists(int'(bus_addr)) ? rf[int'(bus_addr)] : 16'h0;
      end else begin
        wcnt++;
      end
    end
  end

  always @(posedge clk) if (s_valid && s_ready) acc_cnt++;

  task automatic expect_acc(input bit we, input logic [15:0] a, input logic [15:0] d);
    exp_we.push_back(we);
    exp_addr.push_back(a);
    exp_data.push_back(d);
  endtask

  function automatic logic [7:0] img_byte(input int len, input int i);
    return 8'((i * 29 + len * 7 + 3) & 8'hFF);
  endfunction

  task automatic send_bytes(input int len, input int gap);
    for (int i = 0; i < len; i++) begin
      s_data  = img_byte(len, i);
      s_valid = 1'b1;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      if (gap > 0) begin
        s_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    s_valid = 1'b0;
  endtask

  task automatic run_case(input int len, input int lat_i, input int gap,
                          input logic [15:0] c0, input logic [15:0] i0,
                          input logic [15:0] st, input bit extra_start);
    logic [15:0] c1;
    int n;
    lat = lat_i;
    rf[16'h000E] = c0;
    rf[16'h0101] = i0;
    rf[16'h0103] = st;
    acc_cnt = 0;
    c1 = (c0 & 16'hFFE0) | 16'h0017;
    expect_acc(1'b0, 16'h000E, 16'h0);
    expect_acc(1'b1, 16'h000E, c1);                              // R3
    expect_acc(1'b1, 16'h0100, 16'h1000);                        // R4
    expect_acc(1'b0, 16'h0101, 16'h0);
    expect_acc(1'b1, 16'h0101, (i0 & ~16'h3FFC) | 16'hC000);     // R5
    expect_acc(1'b0, 16'h0103, 16'h0);                           // R6
    if (st <= 16'd1) begin
      for (int w = 0; w < len / 2; w++)                          // R7
        expect_acc(1'b1, 16'h0102, {img_byte(len, 2 * w + 1), img_byte(len, 2 * w)});
      expect_acc(1'b1, 16'h0003, 16'h2000);                      // R8
      expect_acc(1'b1, 16'h0004, 16'h0000);
      expect_acc(1'b0, 16'h000E, 16'h0);
      expect_acc(1'b1, 16'h000E, (c1 & 16'hFFE0) | 16'h0001);    // R9
    end
    @(negedge clk);
    img_len = 16'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !ok && !err, "R11", "busy after start", int'({busy, ok, err}), 3'b100);
    n = 0;
    fork
      begin
        if (st <= 16'd1) send_bytes(len, gap);
        else begin
          s_valid = 1'b1;
          s_data  = 8'h5A;
        end
      end
      begin
        if (extra_start) begin
          repeat (10) @(negedge clk);
          img_len = 16'd3;
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
          chk(busy && !err, "R11", "start while busy ignored", int'({busy, err}), 2'b10);
        end
      end
      begin
        while (busy && n < 20000) begin
          @(negedge clk);
          n++;
        end
      end
    join
    if (st > 16'd1) begin
      repeat (20) @(negedge clk);
      s_valid = 1'b0;
      chk(err && !ok && !busy, "R6", "abort flags", int'({err, ok, busy}), 3'b100);
      chk(acc_cnt == 0, "R6", "bytes accepted after bad status", acc_cnt, 0);
    end else begin
      repeat (3) @(negedge clk);
      chk(ok && !err && !busy, "R9", "completion flags", int'({ok, err, busy}), 3'b100);
      chk(rf[16'h000E] == ((c0 & 16'hFFE0) | 16'h0001), "R9", "final control",
          int'(rf[16'h000E]), int'((c0 & 16'hFFE0) | 16'h0001));
      chk(rf[16'h0003] == 16'h2000 && rf[16'h0004] == 16'h0, "R8", "vector halves",
          int'({rf[16'h0004], rf[16'h0003]}), 32'h2000);
      chk(acc_cnt == len, "R12", "bytes accepted", acc_cnt, len);
    end
    chk(exp_addr.size() == 0, "R7", "expected accesses left", exp_addr.size(), 0);
    exp_we.delete();
    exp_addr.delete();
    exp_data.delete();
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog R10 act=%0h exp=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !ok && !err && !bus_req && !s_ready, "R1", "reset state",
        int'({busy, ok, err, bus_req, s_ready}), 0);

    // R2: odd length rejected, nothing on the bus
    img_len = 16'd5;
    start = 1'b1;
    s_valid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err && !busy && !ok, "R2", "odd length flags", int'({err, busy, ok}), 3'b100);
    repeat (20) @(negedge clk);
    s_valid = 1'b0;
    chk(acc_cnt == 0 && !busy, "R2", "odd length stream untouched", acc_cnt, 0);

    run_case(8, 0, 0, 16'hA5C0, 16'h1234, 16'h0000, 1'b0);
    run_case(12, 3, 2, 16'hFFFF, 16'hFFFF, 16'h0001, 1'b1);   // R11 start while busy
    run_case(10, 0, 3, 16'h0E0A, 16'h0003, 16'h0000, 1'b0);   // R12 gappy stream
    run_case(6, 1, 0, 16'h1234, 16'h8001, 16'h0002, 1'b0);    // R6 abort
    run_case(0, 1, 0, 16'h00FF, 16'h4000, 16'h0000, 1'b0);    // R7 empty image
    run_case(64, 4, 0, 16'h7FE3, 16'h5555, 16'h0001, 1'b0);   // R10 slow responder

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule